// File: doc/BRIEF.md
# Program-Memory Bus Strobe Generator

This block paces the address-latch strobe and the active-low program-store strobe of an 8051-style core running from an oscillator clock. It also decides, once per machine cycle, whether code comes from on-chip memory or from the external bus. The core presents a fetch request, an external data request, the program counter and the mode controls ahead of each machine-cycle boundary. The generator samples them there and plays out the strobe pattern for the whole cycle.

A machine cycle lasts 12 oscillator clocks in standard mode and 6 in double-speed mode. It is split into two equal slots. Each slot carries one address-latch pulse at its start and one read-strobe window after that pulse has fallen. The kind of cycle decides which of the four possible strobes actually appear:

- an external fetch;
- an internal fetch;
- an external data access;
- an idle bus.

There is no data path through the block. Every pin is a plain control or status level, and there is no back-pressure.

Top module: `strb_gen`

## Requirements
- R1: A machine cycle lasts 12 clocks when its sampled double-speed flag is 0 and 6 clocks when it is 1. Each cycle is two equal slots. Each slot holds at most one `ale` pulse, so `ale` pulses come once every 6 (or 3) clocks.
- R2: An `ale` pulse is high for slot positions 0 and 1 (2 clocks) in standard mode, and for position 0 only (1 clock) in double-speed mode.
- R3: In an external fetch cycle, `psen_n` goes low twice: at slot positions 3 to 5 in standard mode, and at position 2 in double-speed mode. `psen_n` is never low while `ale` is high.
- R4: `code_ext` is 1 when `ea` is 0 or `pc` is above 0x1FFF, and 0 otherwise. It is sampled at the machine-cycle boundary and held for the whole cycle.
- R5: In a fetch cycle with `code_ext` = 0, `psen_n` stays high.
- R6: When `ale_off` is 1, `ale` stays low in internal-fetch and idle cycles. `ale_off` has no effect in external-fetch or external-data cycles.
- R7: In an external data cycle, `ale` pulses only in slot 0 (one pulse dropped) and `psen_n` stays high (two activations dropped). `xdata_req` takes priority over `fetch_req`.
- R8: `x2_mode`, `ale_off`, `ea`, `pc`, `fetch_req` and `xdata_req` are sampled only on the clock edge that ends a machine cycle. Changes at any other time leave the running cycle's length and strobes unchanged.
- R9: While `rst_n` is low (asynchronous), `ale` = 0, `psen_n` = 1 and `code_ext` = 0. The first machine cycle starts on the first rising clock edge with `rst_n` high, using the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x2_mode | input | 1 | Double-speed timing select (6 clocks per machine cycle) |
| ale_off | input | 1 | Suppress address-latch pulses in non-external cycles |
| ea | input | 1 | High: on-chip code below the limit is allowed; low: all code is external |
| pc | input | 16 | Program counter of the next fetch |
| fetch_req | input | 1 | The next machine cycle fetches code |
| xdata_req | input | 1 | The next machine cycle accesses external data memory |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| code_ext | output | 1 | Current cycle's code source: 1 external, 0 internal |

## Verification
A fetch request and an external data request can both be present at the same boundary. The address-latch disable can also be set while a cycle needs the external bus anyway. The table drives both requests together, once with `ale_off` set. It judges that such a cycle shows exactly one `ale` pulse and no `psen_n` activation. A directed cycle flips the mode and request inputs in the middle of a running cycle. It checks that the cycle keeps its length, its strobes and its code source.

// File: rtl/strb_pkg.sv
package strb_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE      = 2'd0,
    CYC_FETCH_INT = 2'd1,
    CYC_FETCH_EXT = 2'd2,
    CYC_XDATA     = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      x2;
    logic      ale_off;
    logic      ext;
  } cyc_ctrl_t;

endpackage

// File: rtl/strb_phase.sv
module strb_phase #(
  parameter int SLOT_STD = 6,
  parameter int SLOT_X2  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          x2_cur,
  output logic [$clog2(SLOT_STD)-1:0]   pos,
  output logic                          slot,
  output logic                          boundary,
  output logic                          run
);
  localparam int PW = $clog2(SLOT_STD);
  localparam logic [PW-1:0] LAST_STD = PW'(SLOT_STD - 1);
  localparam logic [PW-1:0] LAST_X2  = PW'(SLOT_X2 - 1);

  logic [PW-1:0] last;

  always_comb begin
    last     = x2_cur ? LAST_X2 : LAST_STD;
    boundary = slot && (pos == last);
  end

  // Reset parks the counter on the last position of slot 1, so the first
  // edge after release is a machine-cycle boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= LAST_STD;
      slot <= 1'b1;
      run  <= 1'b0;
    end else begin
      run <= 1'b1;
      if (pos == last) begin
        pos  <= '0;
        slot <= ~slot;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end
endmodule

// File: rtl/strb_cycle.sv
module strb_cycle
  import strb_pkg::*;
#(
  parameter int              PC_W      = 16,
  parameter logic [PC_W-1:0] INT_LIMIT = 'h1FFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary,
  input  logic            x2_mode,
  input  logic            ale_off,
  input  logic            ea,
  input  logic [PC_W-1:0] pc,
  input  logic            fetch_req,
  input  logic            xdata_req,
  output cyc_ctrl_t       ctrl
);
  logic      ext_sel;
  cyc_kind_e kind_nxt;

  always_comb begin
    ext_sel = !ea || (pc > INT_LIMIT);
    if (xdata_req)      kind_nxt = CYC_XDATA;
    else if (fetch_req) kind_nxt = ext_sel ? CYC_FETCH_EXT : CYC_FETCH_INT;
    else                kind_nxt = CYC_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '{kind: CYC_IDLE, x2: 1'b0, ale_off: 1'b0, ext: 1'b0};
    end else if (boundary) begin
      ctrl <= '{kind: kind_nxt, x2: x2_mode, ale_off: ale_off, ext: ext_sel};
    end
  end
endmodule

// File: rtl/strb_decode.sv
module strb_decode
  import strb_pkg::*;
#(
  parameter int SLOT_STD    = 6,
  parameter int ALE_W_STD   = 2,
  parameter int PSEN_ON_STD = 3,
  parameter int ALE_W_X2    = 1,
  parameter int PSEN_ON_X2  = 2
) (
  input  logic                        run,
  input  logic [$clog2(SLOT_STD)-1:0] pos,
  input  logic                        slot,
  input  cyc_ctrl_t                   ctrl,
  output logic                        ale,
  output logic                        psen_n
);
  localparam int PW = $clog2(SLOT_STD);
  localparam logic [PW-1:0] AW_STD = PW'(ALE_W_STD);
  localparam logic [PW-1:0] AW_X2  = PW'(ALE_W_X2);
  localparam logic [PW-1:0] PS_STD = PW'(PSEN_ON_STD);
  localparam logic [PW-1:0] PS_X2  = PW'(PSEN_ON_X2);

  logic [PW-1:0] ale_w;
  logic [PW-1:0] psen_on;
  logic          ale_slot;

  always_comb begin
    ale_w   = ctrl.x2 ? AW_X2 : AW_STD;
    psen_on = ctrl.x2 ? PS_X2 : PS_STD;
    case (ctrl.kind)
      CYC_XDATA:     ale_slot = !slot;
      CYC_FETCH_EXT: ale_slot = 1'b1;
      default:       ale_slot = !ctrl.ale_off;
    endcase
    ale    = run && ale_slot && (pos < ale_w);
    psen_n = !(run && (ctrl.kind == CYC_FETCH_EXT) && (pos >= psen_on));
  end
endmodule

// File: rtl/strb_gen.sv
module strb_gen
  import strb_pkg::*;
#(
  parameter int              PC_W      = 16,
  parameter logic [PC_W-1:0] INT_LIMIT = 'h1FFF,
  parameter int              SLOT_STD  = 6,
  parameter int              SLOT_X2   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x2_mode,
  input  logic            ale_off,
  input  logic            ea,
  input  logic [PC_W-1:0] pc,
  input  logic            fetch_req,
  input  logic            xdata_req,
  output logic            ale,
  output logic            psen_n,
  output logic            code_ext
);
  localparam int PW = $clog2(SLOT_STD);

  cyc_ctrl_t     ctrl;
  logic [PW-1:0] pos;
  logic          slot;
  logic          boundary;
  logic          run;
  logic          mc_x2;
  logic          mc_xdata;

  assign mc_x2    = ctrl.x2;
  assign mc_xdata = (ctrl.kind == CYC_XDATA);
  assign code_ext = ctrl.ext;

  strb_phase #(.SLOT_STD(SLOT_STD), .SLOT_X2(SLOT_X2)) u_phase (
    .clk(clk), .rst_n(rst_n), .x2_cur(mc_x2),
    .pos(pos), .slot(slot), .boundary(boundary), .run(run)
  );

  strb_cycle #(.PC_W(PC_W), .INT_LIMIT(INT_LIMIT)) u_cycle (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .x2_mode(x2_mode), .ale_off(ale_off), .ea(ea), .pc(pc),
    .fetch_req(fetch_req), .xdata_req(xdata_req), .ctrl(ctrl)
  );

  strb_decode #(.SLOT_STD(SLOT_STD)) u_decode (
    .run(run), .pos(pos), .slot(slot), .ctrl(ctrl),
    .ale(ale), .psen_n(psen_n)
  );
endmodule

// File: rtl/strb_chk.sv
module strb_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic psen_n,
  input logic code_ext,
  input logic mc_x2,
  input logic mc_xdata,
  input logic boundary
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && !psen_n)); // R3
  AST_PSEN_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> !$past(ale)); // R3
  AST_ALE_WIDTH_STD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ale) && !mc_x2) |=> ale); // R2
  AST_ALE_WIDTH_X2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ale) && mc_x2) |=> !ale); // R2
  AST_INT_NO_PSEN: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ext |-> psen_n); // R5
  AST_XDATA_NO_PSEN: assert property (@(posedge clk) disable iff (!rst_n)
    mc_xdata |-> psen_n); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(mc_x2)); // R8
  AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(code_ext)); // R4
endmodule

bind strb_gen strb_chk i_strb_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .code_ext(code_ext),
  .mc_x2(mc_x2), .mc_xdata(mc_xdata), .boundary(boundary)
);

// File: tb/test_strb_gen.sv
`timescale 1ns/1ps
module test_strb_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x2_mode = 1'b0, ale_off = 1'b0, ea = 1'b1, fetch_req = 1'b0, xdata_req = 1'b0;
  logic [15:0] pc = 16'h0000;
  logic ale, psen_n, code_ext;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strb_gen i_strb_gen (
    .clk(clk), .rst_n(rst_n), .x2_mode(x2_mode), .ale_off(ale_off), .ea(ea),
    .pc(pc), .fetch_req(fetch_req), .xdata_req(xdata_req),
    .ale(ale), .psen_n(psen_n), .code_ext(code_ext)
  );

  typedef struct packed {
    logic       x2;
    logic       aoff;
    logic       ea;
    logic [15:0] pc;
    logic       f;
    logic       xd;
    logic [1:0] n_ale;
    logic [1:0] n_psen;
    logic       ext;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 16'h0100, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 16'h1FFF, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 16'h2000, 1'b1, 1'b0, 2'd2, 2'd2, 1'b1},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd2, 2'd2, 1'b1},
    '{1'b0, 1'b1, 1'b1, 16'h0100, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 16'h0100, 1'b1, 1'b0, 2'd2, 2'd2, 1'b1},
    '{1'b0, 1'b0, 1'b0, 16'h0100, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 16'h0100, 1'b1, 1'b1, 2'd1, 2'd0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 16'h0300, 1'b1, 1'b0, 2'd2, 2'd2, 1'b1},
    '{1'b1, 1'b0, 1'b1, 16'h0300, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 16'h0300, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 16'h0300, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1},
    '{1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0}
  };

  // measurements of the last machine cycle
  int m_ale, m_ale_hi, m_psen, m_psen_lo, m_ext_bad, m_overlap, m_psen_early;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge just before a boundary edge.
  task automatic run_mc(input logic v_x2, input logic v_aoff, input logic v_ea,
                        input logic [15:0] v_pc, input logic v_f, input logic v_xd,
                        input logic v_ext, input bit flip);
    int len;
    int p;
    logic prev_ale, prev_psen;
    len = v_x2 ? 6 : 12;
    x2_mode = v_x2; ale_off = v_aoff; ea = v_ea; pc = v_pc;
    fetch_req = v_f; xdata_req = v_xd;
    m_ale = 0; m_ale_hi = 0; m_psen = 0; m_psen_lo = 0;
    m_ext_bad = 0; m_overlap = 0; m_psen_early = 0;
    prev_ale = 1'b0; prev_psen = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(posedge clk);
      @(negedge clk);
      p = i % (len / 2);
      if (ale && !prev_ale) m_ale++;
      if (ale) m_ale_hi++;
      if (!psen_n && prev_psen) m_psen++;
      if (!psen_n) begin
        m_psen_lo++;
        if (p < (v_x2 ? 2 : 3)) m_psen_early++;
      end
      if (ale && !psen_n) m_overlap++;
      if (code_ext !== v_ext) m_ext_bad++;
      prev_ale = ale; prev_psen = psen_n;
      if (flip && i == 3) begin
        x2_mode = ~v_x2; fetch_req = ~v_f; ea = ~v_ea; pc = ~v_pc; ale_off = ~v_aoff;
      end
    end
  endtask

  task automatic judge(input string tag, input logic v_x2, input int e_ale,
                       input int e_psen);
    int aw, pw;
    aw = v_x2 ? 1 : 2;
    pw = v_x2 ? 1 : 3;
    chk(m_ale == e_ale, {tag, " R1 R6 R7 ale pulses"}, m_ale, e_ale);
    chk(m_ale_hi == e_ale * aw, {tag, " R2 ale width"}, m_ale_hi, e_ale * aw);
    chk(m_psen == e_psen, {tag, " R3 R5 psen pulses"}, m_psen, e_psen);
    chk(m_psen_lo == e_psen * pw, {tag, " R3 psen width"}, m_psen_lo, e_psen * pw);
    chk(m_psen_early == 0, {tag, " R3 psen placement"}, m_psen_early, 0);
    chk(m_overlap == 0, {tag, " R3 overlap"}, m_overlap, 0);
    chk(m_ext_bad == 0, {tag, " R4 code_ext"}, m_ext_bad, 0);
  endtask

  initial begin
    // R9: outputs idle during reset
    repeat (3) @(negedge clk);
    chk(ale === 1'b0, "R9 reset ale", int'(ale), 0);
    chk(psen_n === 1'b1, "R9 reset psen_n", int'(psen_n), 1);
    chk(code_ext === 1'b0, "R9 reset code_ext", int'(code_ext), 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      run_mc(VECS[k].x2, VECS[k].aoff, VECS[k].ea, VECS[k].pc, VECS[k].f,
             VECS[k].xd, VECS[k].ext, 1'b0);
      judge($sformatf("vec%0d", k), VECS[k].x2, int'(VECS[k].n_ale), int'(VECS[k].n_psen));
    end

    // R8: mid-cycle changes do not touch the running standard external fetch
    run_mc(1'b0, 1'b0, 1'b0, 16'h0040, 1'b1, 1'b0, 1'b1, 1'b1);
    judge("R8 flip std", 1'b0, 2, 2);
    // R8: mid-cycle changes do not touch a running double-speed internal cycle
    run_mc(1'b1, 1'b1, 1'b1, 16'h0040, 1'b1, 1'b0, 1'b0, 1'b1);
    judge("R8 flip x2", 1'b1, 0, 0);
    // next cycle after a flip runs with the newly driven inputs
    run_mc(1'b0, 1'b0, 1'b0, 16'h0040, 1'b1, 1'b0, 1'b1, 1'b0);
    judge("R8 after flip", 1'b0, 2, 2);

    // R9: reset in the middle of a cycle, then restart on first edge
    x2_mode = 1'b1; ea = 1'b0; fetch_req = 1'b1; xdata_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ale === 1'b0 && psen_n === 1'b1 && code_ext === 1'b0, "R9 mid reset",
        int'({ale, psen_n, code_ext}), 3'b010);
    @(negedge clk);
    rst_n = 1'b1;
    run_mc(1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b0);
    judge("R9 first cycle", 1'b1, 2, 2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule